// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block carries data words between two unrelated clock domains. A producer in the write clock domain pushes words through a valid/ready port, and a consumer in the read clock domain takes them through a second valid/ready port. The read side works in fall-through fashion. The oldest stored word is moved into an output register without being asked for. It is presented with `rd_valid` high until the consumer takes it.

The storage array has 2^AW entries. The output register is one more place to hold a word, so the block holds 2^AW + 1 words in total. Read and write counters are one bit wider than the array address. Each domain sends its counters to the other domain in Gray code, through a chain of two flops.

The write domain computes three flags from its own view of the fill level:
- room to write (`wr_ready`),
- a programmable near-full flag,
- a more-than-half-full flag.

The read domain computes the fall-through valid and a programmable near-empty flag. The two threshold offsets are captured while reset is held. A read chip select gates the whole read port. When it is low, reads have no effect and the data output is driven to zero.

Back-pressure rules:
- Write port: a word is stored on the write clock edge where `wr_valid` and `wr_ready` are both high.
- Read port: a word is removed on the read clock edge where `rd_valid` and `rd_ready` are both high.
- A presented word and `rd_valid` stay unchanged until that read edge.

Top module: `fwft_async_fifo`

## Requirements
- R1: With `rst_n` low on a few edges of both clocks, the block leaves reset empty. `wr_ready`=1, `near_full_n`=1, `over_half_n`=1, `rd_valid`=0 and `near_empty_n`=0.
- R2: The first word written into an empty FIFO appears on `rd_data` with `rd_valid`=1 without any read request, no later than the fourth `rclk` rising edge after the write edge.
- R3: With no reads, exactly 2^AW + 1 words are accepted. `wr_ready` stays 1 after 2^AW words and is 0 once 2^AW + 1 words are held.
- R4: A `wr_valid` pulse while `wr_ready`=0 stores nothing and does not disturb the stored words.
- R5: Words leave in the order they were written, across the full capacity.
- R6: An `rd_ready` pulse while `rd_valid`=0 removes nothing. Words written later are still delivered in order.
- R7: While `rd_cs`=0, `rd_data` is all zeros, `rd_valid` is 0 and `rd_ready` has no effect. The presented word is still there when `rd_cs` returns to 1.
- R8: `near_full_n` is 0 exactly when the fill level is at least (2^AW + 1) minus the full offset. After a read that drops the level below that threshold, it returns to 1 no later than the third `wclk` rising edge.
- R9: `near_empty_n` is 0 exactly when the fill level is at most the empty offset.
- R10: `over_half_n` is 0 exactly when the fill level is greater than half the capacity, that is at least 2^(AW-1) + 1 words.
- R11: After one read from a full FIFO, `wr_ready` returns to 1 no later than the third `wclk` rising edge after the read edge.
- R12: Offset capture:
  - When `cfg_load`=1 while `rst_n` is low, the offsets are taken from `cfg_full_ofs` and `cfg_empty_ofs`.
  - When `cfg_load`=0 during reset, both offsets become DEF_OFS (127).
  - The `cfg_*` inputs are ignored outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write domain clock |
| rclk | input | 1 | Read domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| cfg_load | input | 1 | During reset, 1 takes the offsets from the cfg inputs and 0 selects DEF_OFS |
| cfg_full_ofs | input | AW+1 | Near-full offset, in words |
| cfg_empty_ofs | input | AW+1 | Near-empty offset, in words |
| wr_valid | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| wr_ready | output | 1 | Room for a word in the FIFO |
| rd_cs | input | 1 | Read port select; 0 disables reads and zeroes the output |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A word is presented on rd_data |
| rd_data | output | DW | Presented word, or zero when deselected |
| near_full_n | output | 1 | Low when the level is within the full offset of capacity |
| over_half_n | output | 1 | Low when more than half of the capacity is used |
| near_empty_n | output | 1 | Low when the level is at or below the empty offset |

## Verification
The bench fills the FIFO to 2^AW + 1 words. A design that counted only the array would refuse the last word, and one that ignored the output register would overwrite an unread slot. It also times the release of `wr_ready` and `near_full_n` after a single read from the top, which exposes a missing or extra synchronizer stage. Each flag is stepped across its threshold one word at a time, so an off-by-one comparison against the offset or the half mark shows up. Reads on an empty FIFO, writes on a full one, and traffic with the chip select low are checked as well: a design that let any of them move a pointer would later drop, repeat or invent words.

// File: rtl/fifo_gray_sync.sv
`timescale 1ns/1ps
// Brings a Gray-coded counter into another clock domain and returns it in binary.
module fifo_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage [STAGES];
  logic [W-1:0] g_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign g_last = stage[STAGES-1];

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      assign bin_out[b] = ^g_last[W-1:b];
    end
  endgenerate
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
// Register-file storage: write in the write domain, combinational read.
module fifo_store #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
// Write domain: write counter, room check, near-full and half flags.
module fifo_wr_ctl #(
  parameter int AW      = 8,
  parameter int DEF_OFS = 127
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [AW:0] cfg_full_ofs,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [AW:0] rc_gray,
  input  logic [AW:0] rm_gray,
  output logic [AW:0] w_gray,
  output logic        mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic        near_full_n,
  output logic        over_half_n
);
  localparam int PW       = AW + 1;
  localparam int PW1      = PW + 1;
  localparam int MEMD     = 1 << AW;
  localparam int CAP      = MEMD + 1;
  localparam int HALF_MIN = (MEMD >> 1) + 1;

  logic [PW-1:0] w_bin, w_nxt, rc_bin, rm_bin, level, mem_cnt, full_ofs;
  logic          full;

  fifo_gray_sync #(.W(PW), .STAGES(2)) u_sync_rc (
    .clk(wclk), .rst_n(rst_n), .gray_in(rc_gray), .bin_out(rc_bin));
  fifo_gray_sync #(.W(PW), .STAGES(2)) u_sync_rm (
    .clk(wclk), .rst_n(rst_n), .gray_in(rm_gray), .bin_out(rm_bin));

  // level: words not yet taken by the consumer; mem_cnt: words in the array
  assign level   = w_bin - rc_bin;
  assign mem_cnt = w_bin - rm_bin;
  assign full    = (mem_cnt == PW'(MEMD)) || (level == PW'(CAP));

  assign wr_ready  = !full;
  assign mem_we    = wr_valid && !full;
  assign mem_waddr = w_bin[AW-1:0];
  assign w_nxt     = w_bin + PW'(1);

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
    end else if (mem_we) begin
      w_bin  <= w_nxt;
      w_gray <= w_nxt ^ (w_nxt >> 1);
    end
  end

  // offset captured only while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) full_ofs <= cfg_load ? cfg_full_ofs : PW'(DEF_OFS);
  end

  assign near_full_n = !((PW1'(level) + PW1'(full_ofs)) >= PW1'(CAP));
  assign over_half_n = !(level >= PW'(HALF_MIN));

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (mem_cnt <= PW'(MEMD)) && (level <= PW'(CAP)));
  assert_blocked_write_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(w_bin));
  assert_write_step_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (w_bin == $past(w_bin) + PW'(1)));
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
// Read domain: array read counter, fall-through register, consumed counter, near-empty.
module fifo_rd_ctl #(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFS = 127
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW:0]   cfg_empty_ofs,
  input  logic          rd_cs,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic [AW:0]   w_gray,
  output logic [AW:0]   rm_gray,
  output logic [AW:0]   rc_gray,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          near_empty_n
);
  localparam int PW  = AW + 1;
  localparam int CAP = (1 << AW) + 1;

  logic [PW-1:0] w_bin, rm_bin, rc_bin, rm_nxt, rc_nxt, level, empty_ofs;
  logic [DW-1:0] out_q;
  logic          out_valid, mem_has, pop, load;

  fifo_gray_sync #(.W(PW), .STAGES(2)) u_sync_w (
    .clk(rclk), .rst_n(rst_n), .gray_in(w_gray), .bin_out(w_bin));

  assign mem_has   = (w_bin != rm_bin);
  assign rd_valid  = out_valid && rd_cs;
  assign rd_data   = rd_cs ? out_q : '0;
  assign pop       = rd_valid && rd_ready;
  assign load      = mem_has && (!out_valid || pop);
  assign mem_raddr = rm_bin[AW-1:0];
  assign rm_nxt    = rm_bin + PW'(1);
  assign rc_nxt    = rc_bin + PW'(1);

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      out_q     <= '0;
      out_valid <= 1'b0;
      rm_bin    <= '0;
      rm_gray   <= '0;
    end else if (load) begin
      out_q     <= mem_rdata;
      out_valid <= 1'b1;
      rm_bin    <= rm_nxt;
      rm_gray   <= rm_nxt ^ (rm_nxt >> 1);
    end else if (pop) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rc_bin  <= '0;
      rc_gray <= '0;
    end else if (pop) begin
      rc_bin  <= rc_nxt;
      rc_gray <= rc_nxt ^ (rc_nxt >> 1);
    end
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) empty_ofs <= cfg_load ? cfg_empty_ofs : PW'(DEF_OFS);
  end

  assign level        = w_bin - rc_bin;
  assign near_empty_n = !(level <= empty_ofs);

  assert_empty_read_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !pop |=> $stable(rc_bin));
  assert_hold_word_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_valid && !pop) |=> (out_valid && $stable(out_q)));
  assert_out_track_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (rm_bin - rc_bin) == PW'(out_valid));
  assert_level_bound_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    level <= PW'(CAP));
endmodule

// File: rtl/fwft_async_fifo.sv
`timescale 1ns/1ps
// Dual-clock fall-through FIFO top.
module fwft_async_fifo #(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFS = 127
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW:0]   cfg_full_ofs,
  input  logic [AW:0]   cfg_empty_ofs,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_cs,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          near_full_n,
  output logic          over_half_n,
  output logic          near_empty_n
);
  logic [AW:0]   w_gray, rm_gray, rc_gray;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_rdata;

  fifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata));

  fifo_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_full_ofs(cfg_full_ofs),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rc_gray(rc_gray), .rm_gray(rm_gray),
    .w_gray(w_gray), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .near_full_n(near_full_n), .over_half_n(over_half_n));

  fifo_rd_ctl #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_empty_ofs(cfg_empty_ofs),
    .rd_cs(rd_cs), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .w_gray(w_gray), .rm_gray(rm_gray), .rc_gray(rc_gray), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .near_empty_n(near_empty_n));
endmodule

// File: tb/tb_fwft_async_fifo.sv
`timescale 1ns/1ps
module tb_fwft_async_fifo;
  localparam int AW  = 8;
  localparam int DW  = 18;
  localparam int PW  = AW + 1;
  localparam int CAP = (1 << AW) + 1;

  logic wclk = 0, rclk = 0, rst_n = 0, cfg_load = 0;
  logic [PW-1:0] cfg_full_ofs = '0, cfg_empty_ofs = '0;
  logic wr_valid = 0, rd_cs = 1, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, near_full_n, over_half_n, near_empty_n;
  logic [DW-1:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 wclk = ~wclk;   // 200 MHz write clock
  always #3.5 rclk = ~rclk;

  fwft_async_fifo #(.DW(DW), .AW(AW), .DEF_OFS(127)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_full_ofs(cfg_full_ofs), .cfg_empty_ofs(cfg_empty_ofs),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_cs(rd_cs), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .near_full_n(near_full_n), .over_half_n(over_half_n), .near_empty_n(near_empty_n));

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 32'h15000);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit load, input int m, input int n);
    rst_n = 0; wr_valid = 0; rd_ready = 0; rd_cs = 1;
    cfg_load = load; cfg_full_ofs = PW'(m); cfg_empty_ofs = PW'(n);
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    rst_n = 1; cfg_load = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk); wr_valid = 1; wr_data = d;
    @(negedge wclk); wr_valid = 0;
  endtask

  task automatic pop_chk(input logic [DW-1:0] exp, input string tag);
    @(negedge rclk);
    chk({tag, " valid"}, rd_valid, 1);
    chk({tag, " data"}, rd_data, exp);
    rd_ready = 1;
    @(negedge rclk); rd_ready = 0;
  endtask

  // R1, R12: reset state and default offsets
  task automatic t_defaults();
    do_reset(0, 3, 3);
    settle();
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 near_full_n", near_full_n, 1);
    chk("R1 over_half_n", over_half_n, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 near_empty_n", near_empty_n, 0);
    // outside reset the cfg inputs must be ignored (R12)
    cfg_load = 1; cfg_full_ofs = PW'(3); cfg_empty_ofs = PW'(3);
    for (int i = 0; i < 127; i++) push(pat(i));
    settle();
    chk("R12 default empty ofs at 127", near_empty_n, 0);
    push(pat(127)); settle();
    chk("R12 default empty ofs at 128", near_empty_n, 1);
    push(pat(128)); settle();
    chk("R12 default full ofs at 129", near_full_n, 1);
    push(pat(129)); settle();
    chk("R12 default full ofs at 130", near_full_n, 0);
    cfg_load = 0;
  endtask

  // R2, R7, R6: fall-through, chip select, empty reads
  task automatic t_fwft();
    int cnt;
    do_reset(1, 5, 4);
    settle();
    @(negedge wclk); wr_valid = 1; wr_data = pat(0);
    @(posedge wclk); #1 wr_valid = 0;
    cnt = 0;
    while (!rd_valid && cnt < 10) begin
      @(posedge rclk); #1; cnt++;
    end
    chk("R2 fall-through edges <= 4", longint'(cnt <= 4), 1);
    chk("R2 first word", rd_data, pat(0));
    @(negedge rclk); rd_cs = 0; #1;
    chk("R7 data zero when deselected", rd_data, 0);
    chk("R7 valid low when deselected", rd_valid, 0);
    rd_ready = 1;
    repeat (3) @(negedge rclk);
    rd_ready = 0; rd_cs = 1; #1;
    chk("R7 word kept valid", rd_valid, 1);
    chk("R7 word kept data", rd_data, pat(0));
    pop_chk(pat(0), "R7 pop");
    settle();
    chk("R6 empty after pop", rd_valid, 0);
    @(negedge rclk); rd_ready = 1;
    repeat (5) @(negedge rclk);
    rd_ready = 0;
    push(pat(1)); push(pat(2));
    settle();
    pop_chk(pat(1), "R6 first after empty reads");
    pop_chk(pat(2), "R6 second after empty reads");
    settle();
    chk("R6 empty at end", rd_valid, 0);
    chk("R9 near-empty at zero", near_empty_n, 0);
  endtask

  // R3, R4, R5, R8, R9, R10, R11: full depth and flag thresholds
  task automatic t_fill();
    int cnt;
    do_reset(1, 5, 4);
    settle();
    for (int i = 0; i < CAP; i++) begin
      push(pat(i));
      if (i + 1 == 4)   begin settle(); chk("R9 level 4",  near_empty_n, 0); end
      if (i + 1 == 5)   begin settle(); chk("R9 level 5",  near_empty_n, 1); end
      if (i + 1 == 128) begin settle(); chk("R10 level 128", over_half_n, 1); end
      if (i + 1 == 129) begin settle(); chk("R10 level 129", over_half_n, 0); end
      if (i + 1 == 251) begin settle(); chk("R8 level 251", near_full_n, 1); end
      if (i + 1 == 252) begin settle(); chk("R8 level 252", near_full_n, 0); end
      if (i + 1 == CAP - 1) begin settle(); chk("R3 room at 256", wr_ready, 1); end
    end
    settle();
    chk("R3 full at 257", wr_ready, 0);
    @(negedge wclk); wr_valid = 1; wr_data = '1;
    repeat (4) @(negedge wclk);
    wr_valid = 0;
    chk("R4 still full", wr_ready, 0);
    // timed read from full
    @(negedge rclk);
    chk("R5 word 0", rd_data, pat(0));
    rd_ready = 1;
    @(posedge rclk); #1 rd_ready = 0;
    cnt = 0;
    while (!wr_ready && cnt < 10) begin
      @(posedge wclk); #1; cnt++;
    end
    chk("R11 room within 3 wclk edges", longint'(cnt <= 3), 1);
    for (int i = 1; i < 5; i++) pop_chk(pat(i), "R5 order");
    settle();
    chk("R8 still near full at 252", near_full_n, 0);
    @(negedge rclk);
    chk("R5 word 5", rd_data, pat(5));
    rd_ready = 1;
    @(posedge rclk); #1 rd_ready = 0;
    cnt = 0;
    while (!near_full_n && cnt < 10) begin
      @(posedge wclk); #1; cnt++;
    end
    chk("R8 release within 3 wclk edges", longint'(cnt <= 3), 1);
    for (int i = 6; i < CAP; i++) pop_chk(pat(i), "R5 order");
    settle();
    chk("R4 blocked word never stored", rd_valid, 0);
    chk("R9 empty after drain", near_empty_n, 0);
  endtask

  initial begin
    t_defaults();
    t_fwft();
    t_fill();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule